// File: doc/BRIEF.md
# Flash Status Read Generator

This block forms the status word a host reads back from a flash array while an embedded program or erase runs, and while an erase is suspended. A controller elsewhere supplies the current operation mode, a read strobe, two per-read flags and bit 7 of the word being programmed. The block returns five status bits, a ready/busy level and a select. The select tells the read-data multiplexer whether to return status or array contents.

Two toggle flip-flops advance once per completed read. A completed read is the falling end of the strobe. The first flip-flop steps on every read while a program or erase is active. The second steps only on reads that hit a block being erased. After an erase fails, it steps only on reads that hit a faulty erasing block. This lets software tell which blocks are involved by reading twice. Bus timing is generated elsewhere.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, in idle mode (code 0), `rdy` is 1, `status_sel` is 0 and all five status bits are 0.
- R2: Mode codes are 0 idle, 1 program, 2 erase waiting for more blocks, 3 erase running, 4 erase suspended and 5 failed. Codes 6 and 7 act as idle. `rdy` is 0 in codes 1, 2, 3 and 5, and 1 in codes 0 and 4. In idle, `status_sel` is 0 and reads move no toggle.
- R3: `st_dq7` is the inverse of `wr_bit7` in program mode and 0 in erase modes 2 and 3. In mode 5 it is the inverse of `wr_bit7` when the failed operation was a program, and 0 when it was an erase.
- R4: `st_dq6` inverts once after each completed read in modes 1, 2, 3 and 5, whatever the address flags are.
- R5: In modes 2 and 3, `st_dq2` inverts after a read only when `in_erase_blk` is 1. Otherwise it keeps its value.
- R6: In mode 4, a read with `in_erase_blk` 0 gives `status_sel` 0 and all status bits 0. A read with `in_erase_blk` 1 gives status with `st_dq7` 1 and `st_dq3` 1, `st_dq6` held and `st_dq2` inverting after each read. Going from mode 4 back to mode 3 keeps both toggle values.
- R7: `st_dq5` is 1 exactly in mode 5. After an erase has failed, `st_dq2` inverts only on reads with both `in_erase_blk` and `blk_bad` at 1.
- R8: `st_dq3` is 0 in modes 1 and 2. It is 1 in mode 3, in mode 4 on an erasing block, and in mode 5 after an erase.
- R9: Both toggles return to 0 when a new operation starts. A program starts on entering mode 1 from any other mode. An erase starts on entering mode 2 or 3 from idle.
- R10: A toggle advances only when the strobe falls. Holding `rd_stb` high for several cycles gives exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_mode | input | MODE_W (3) | Operation mode code |
| rd_stb | input | 1 | Read strobe; a read completes when it falls |
| in_erase_blk | input | 1 | Read address lies in a block selected for erase |
| blk_bad | input | 1 | The addressed block failed to erase |
| wr_bit7 | input | 1 | Bit 7 of the word being programmed |
| st_dq7 | output | 1 | Polling bit |
| st_dq6 | output | 1 | Any-address toggle bit |
| st_dq5 | output | 1 | Failure bit |
| st_dq3 | output | 1 | Erase-started bit |
| st_dq2 | output | 1 | Erasing-block toggle bit |
| rdy | output | 1 | Ready (1) or busy (0) |
| status_sel | output | 1 | 1 returns status, 0 returns array data |

## Verification
The hardest case to reach is the faulty-block toggle in the failed state. It needs an erase in progress, then the failed mode, and it depends on which operation came before, because the block remembers that. The bench walks the mode sequence idle, erase, suspend, nested program, back to suspend, resume and failure. In each mode it sweeps all four combinations of the two address flags. A model built from the requirements carries both toggle values across each transition. A held strobe and a program entered from suspend cover the one-step rule and the clear-on-start rule.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [2:0] {
      FM_IDLE  = 3'd0,
      FM_PROG  = 3'd1,
      FM_EWAIT = 3'd2,
      FM_ERUN  = 3'd3,
      FM_SUSP  = 3'd4,
      FM_FAIL  = 3'd5
   } fsr_mode_e;

   localparam int NUM_TOG = 2;
   localparam int TOG_ANY = 0;
   localparam int TOG_BLK = 1;
   localparam int MAX_CODE = 5;

   function automatic logic is_busy(fsr_mode_e m);
      return (m == FM_PROG) || (m == FM_EWAIT) || (m == FM_ERUN) || (m == FM_FAIL);
   endfunction

   function automatic logic is_erasing(fsr_mode_e m);
      return (m == FM_EWAIT) || (m == FM_ERUN);
   endfunction
endpackage

// File: rtl/fsr_strobe_end.sv
module fsr_strobe_end (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   output logic done
);
   logic stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= stb;
   end

   assign done = stb_q & ~stb;
endmodule

// File: rtl/fsr_op_track.sv
module fsr_op_track
   import fsr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  fsr_mode_e mode,
   output logic      op_start,
   output logic      last_prog
);
   fsr_mode_e mode_q;
   logic      prog_start, erase_start;

   always_comb begin
      prog_start  = (mode == FM_PROG) && (mode_q != FM_PROG);
      erase_start = is_erasing(mode) && (mode_q == FM_IDLE);
      op_start    = prog_start | erase_start;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= FM_IDLE;
         last_prog <= 1'b0;
      end else begin
         mode_q <= mode;
         if (mode == FM_PROG)
            last_prog <= 1'b1;
         else if (is_erasing(mode) || (mode == FM_SUSP))
            last_prog <= 1'b0;
      end
   end
endmodule

// File: rtl/fsr_toggle_cell.sv
module fsr_toggle_cell #(
   parameter bit INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= INIT;
      else if (clr)  q <= INIT;
      else if (step) q <= ~q;
   end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import fsr_pkg::*;
#(
   parameter int MODE_W   = 3,
   parameter bit TOG_INIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] op_mode,
   input  logic              rd_stb,
   input  logic              in_erase_blk,
   input  logic              blk_bad,
   input  logic              wr_bit7,
   output logic              st_dq7,
   output logic              st_dq6,
   output logic              st_dq5,
   output logic              st_dq3,
   output logic              st_dq2,
   output logic              rdy,
   output logic              status_sel
);
   localparam logic [MODE_W-1:0] TOP_CODE = MODE_W'(MAX_CODE);

   initial begin
      if (MODE_W < 3) $error("flash_status_gen: MODE_W must be at least 3");
   end

   fsr_mode_e          mode;
   logic               op_start, last_prog, rd_done;
   logic [NUM_TOG-1:0] tog_en, tog_q;

   always_comb begin
      if (op_mode > TOP_CODE) mode = FM_IDLE;
      else                    mode = fsr_mode_e'(op_mode[2:0]);
   end

   fsr_strobe_end u_end (
      .clk  (clk),
      .rst_n(rst_n),
      .stb  (rd_stb),
      .done (rd_done)
   );

   fsr_op_track u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .op_start (op_start),
      .last_prog(last_prog)
   );

   always_comb begin
      tog_en          = '0;
      tog_en[TOG_ANY] = is_busy(mode);
      tog_en[TOG_BLK] = ((is_erasing(mode) || (mode == FM_SUSP)) && in_erase_blk)
                      || ((mode == FM_FAIL) && !last_prog && in_erase_blk && blk_bad);
   end

   for (genvar g = 0; g < NUM_TOG; g++) begin : g_tog
      fsr_toggle_cell #(.INIT(TOG_INIT)) u_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (op_start),
         .step (rd_done & tog_en[g]),
         .q    (tog_q[g])
      );
   end

   always_comb begin
      rdy        = ~is_busy(mode);
      status_sel = is_busy(mode) || ((mode == FM_SUSP) && in_erase_blk);
      st_dq7 = 1'b0;
      st_dq3 = 1'b0;
      unique case (mode)
         FM_PROG:  st_dq7 = ~wr_bit7;
         FM_ERUN:  st_dq3 = 1'b1;
         FM_SUSP:  begin st_dq7 = 1'b1; st_dq3 = 1'b1; end
         FM_FAIL:  begin st_dq7 = last_prog & ~wr_bit7; st_dq3 = ~last_prog; end
         default:  ;
      endcase
      st_dq7 = st_dq7 & status_sel;
      st_dq3 = st_dq3 & status_sel;
      st_dq6 = tog_q[TOG_ANY] & status_sel;
      st_dq2 = tog_q[TOG_BLK] & status_sel;
      st_dq5 = (mode == FM_FAIL);
   end
endmodule

// File: rtl/fsr_status_chk.sv
module fsr_status_chk #(
   parameter int MODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [MODE_W-1:0] op_mode,
   input logic              rd_stb,
   input logic              in_erase_blk,
   input logic              blk_bad,
   input logic              wr_bit7,
   input logic              st_dq7,
   input logic              st_dq6,
   input logic              st_dq5,
   input logic              st_dq3,
   input logic              st_dq2,
   input logic              rdy,
   input logic              status_sel
);
   localparam logic [MODE_W-1:0] C_PROG = MODE_W'(1);
   localparam logic [MODE_W-1:0] C_EWT  = MODE_W'(2);
   localparam logic [MODE_W-1:0] C_ERUN = MODE_W'(3);
   localparam logic [MODE_W-1:0] C_SUSP = MODE_W'(4);
   localparam logic [MODE_W-1:0] C_FAIL = MODE_W'(5);

   a_r2_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == C_PROG || op_mode == C_EWT || op_mode == C_ERUN || op_mode == C_FAIL) |-> !rdy);

   a_r3_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == C_EWT || op_mode == C_ERUN) |-> !st_dq7);

   a_r4_any_toggle_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == C_PROG && $past(op_mode) == C_PROG && $fell(rd_stb))
      |=> (op_mode != C_PROG || st_dq6 != $past(st_dq6)));

   a_r5_blk_toggle_still: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == C_ERUN && $past(op_mode) == C_ERUN && !in_erase_blk && $fell(rd_stb))
      |=> (op_mode != C_ERUN || $stable(st_dq2)));

   a_r6_array_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == C_SUSP && !in_erase_blk) |-> (!status_sel && rdy));

   a_r7_fail_flag: assert property (@(posedge clk) disable iff (!rst_n)
      st_dq5 == (op_mode == C_FAIL));

   a_r10_held_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && $past(rd_stb) && op_mode == C_PROG && $past(op_mode) == C_PROG
       && $past(op_mode, 2) == C_PROG) |-> $stable(st_dq6));
endmodule

bind flash_status_gen fsr_status_chk #(.MODE_W(MODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_mode     (op_mode),
   .rd_stb      (rd_stb),
   .in_erase_blk(in_erase_blk),
   .blk_bad     (blk_bad),
   .wr_bit7     (wr_bit7),
   .st_dq7      (st_dq7),
   .st_dq6      (st_dq6),
   .st_dq5      (st_dq5),
   .st_dq3      (st_dq3),
   .st_dq2      (st_dq2),
   .rdy         (rdy),
   .status_sel  (status_sel)
);

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_mode = 3'd0;
   logic       rd_stb = 1'b0, in_erase_blk = 1'b0, blk_bad = 1'b0, wr_bit7 = 1'b0;
   logic       st_dq7, st_dq6, st_dq5, st_dq3, st_dq2, rdy, status_sel;

   always #(CLK_P/2) clk = ~clk;

   flash_status_gen uut (
      .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .rd_stb(rd_stb),
      .in_erase_blk(in_erase_blk), .blk_bad(blk_bad), .wr_bit7(wr_bit7),
      .st_dq7(st_dq7), .st_dq6(st_dq6), .st_dq5(st_dq5), .st_dq3(st_dq3),
      .st_dq2(st_dq2), .rdy(rdy), .status_sel(status_sel)
   );

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   // model state derived from the requirements
   int cur = 0;
   bit t6 = 1'b0, t2 = 1'b0, lp = 1'b0;

   function automatic bit busy(int m);
      return (m == 1) || (m == 2) || (m == 3) || (m == 5);
   endfunction

   // order: {sel, rdy, dq7, dq6, dq5, dq3, dq2}
   function automatic logic [6:0] expect_vec(bit in, bit d);
      bit sel, q7, q3;
      sel = busy(cur) || (cur == 4 && in);
      q7  = (cur == 1) ? ~d : (cur == 4) ? in : (cur == 5) ? (lp & ~d) : 1'b0;
      q3  = (cur == 3) || (cur == 4 && in) || (cur == 5 && !lp);
      return {sel, ~busy(cur), q7 & sel, t6 & sel, cur == 5, q3 & sel, t2 & sel};
   endfunction

   task automatic compare(string tag, logic [6:0] exp);
      logic [6:0] act;
      act = {status_sel, rdy, st_dq7, st_dq6, st_dq5, st_dq3, st_dq2};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s mode=%0d act=%b exp=%b (sel rdy dq7 dq6 dq5 dq3 dq2)",
                  tag, cur, act, exp);
      end
   endtask

   task automatic set_mode(logic [2:0] m);
      int eff;
      @(negedge clk);
      op_mode = m;
      eff = (m > 3'd5) ? 0 : int'(m);
      if ((eff == 1 && cur != 1) || ((eff == 2 || eff == 3) && cur == 0)) begin
         t6 = 1'b0; t2 = 1'b0;   // R9
      end
      if (eff == 1) lp = 1'b1;
      else if (eff == 2 || eff == 3 || eff == 4) lp = 1'b0;
      cur = eff;
      @(posedge clk);
   endtask

   task automatic check_now(string tag, bit in, bit bad);
      @(negedge clk);
      in_erase_blk = in; blk_bad = bad;
      #1;
      compare(tag, expect_vec(in, wr_bit7));
   endtask

   task automatic do_read(string tag, bit in, bit bad, int hold);
      @(negedge clk);
      in_erase_blk = in; blk_bad = bad; rd_stb = 1'b1;
      @(negedge clk);
      compare(tag, expect_vec(in, wr_bit7));
      for (int k = 1; k < hold; k++) begin
         @(negedge clk);
         compare("R10 held strobe", expect_vec(in, wr_bit7));
      end
      rd_stb = 1'b0;
      @(posedge clk);
      if (busy(cur)) t6 = ~t6;
      if (((cur == 2 || cur == 3 || cur == 4) && in) || (cur == 5 && !lp && in && bad)) t2 = ~t2;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      check_now("R1 reset state", 1'b0, 1'b0);
      // R2: unused codes behave as idle, idle reads do not toggle
      set_mode(3'd6); do_read("R2 code6", 1'b1, 1'b1, 1);
      set_mode(3'd7); do_read("R2 code7", 1'b1, 1'b0, 1);
      set_mode(3'd0); do_read("R2 idle read", 1'b1, 1'b1, 1);
      // program: R3/R4 over flag sweep and both data values
      wr_bit7 = 1'b1;
      set_mode(3'd1);
      for (int i = 0; i < 4; i++) do_read("R4 program toggle", i[0], i[1], 1);
      wr_bit7 = 1'b0;
      for (int i = 0; i < 4; i++) do_read("R3 program poll", i[1], i[0], 1);
      do_read("R10 long strobe", 1'b0, 1'b0, 5);
      do_read("R10 after long", 1'b1, 1'b0, 1);
      set_mode(3'd0); check_now("R2 idle after program", 1'b0, 1'b0);
      // erase waiting and running: R5, R8
      set_mode(3'd2);
      for (int i = 0; i < 8; i++) do_read("R5 erase wait", (i % 3) == 0, i[0], 1);
      set_mode(3'd3);
      for (int i = 0; i < 8; i++) do_read("R8 erase run", i[1] ^ i[0], i[2], 1);
      // suspend: R6
      set_mode(3'd4);
      for (int i = 0; i < 6; i++) do_read("R6 suspend", i[0], i[1], 1);
      set_mode(3'd3);
      for (int i = 0; i < 3; i++) do_read("R6 resume keeps toggles", 1'b1, 1'b0, 1);
      // program inside suspend clears toggles: R9
      set_mode(3'd4);
      do_read("R6 suspend again", 1'b1, 1'b0, 1);
      wr_bit7 = 1'b1;
      set_mode(3'd1);
      check_now("R9 start clears", 1'b0, 1'b0);
      do_read("R9 nested program", 1'b0, 1'b0, 1);
      set_mode(3'd4);
      for (int i = 0; i < 4; i++) do_read("R9 back to suspend", i[0], 1'b0, 1);
      // failed erase: R7
      set_mode(3'd3);
      do_read("R8 erase run", 1'b1, 1'b0, 1);
      set_mode(3'd5);
      for (int i = 0; i < 8; i++) do_read("R7 failed erase", i[0], i[1], 1);
      set_mode(3'd0); check_now("R7 flag cleared", 1'b1, 1'b1);
      // failed program: R3, R7
      wr_bit7 = 1'b0;
      set_mode(3'd1);
      do_read("R4 program", 1'b1, 1'b1, 1);
      set_mode(3'd5);
      for (int i = 0; i < 4; i++) do_read("R3 failed program", i[0], i[1], 1);
      set_mode(3'd0);
      // erase started from idle clears toggles: R9
      set_mode(3'd3);
      do_read("R9 erase start", 1'b1, 1'b0, 1);
      do_read("R5 erase run", 1'b0, 1'b0, 1);
      set_mode(3'd0);
      check_now("R1 idle at end", 1'b0, 1'b0);
      finish_run();
   end
endmodule